// File: doc/BRIEF.md
# Volume Transposer

This block sits between a two-dimensional transform stage and a final one-dimensional transform along the third axis. Its input is a continuous stream of coefficient rows, one row of `LANES` words per accepted cycle. Every group of `LANES` consecutive rows forms one square matrix, and every `LANES` consecutive matrices form one volume. Its output is one vector per accepted cycle. That vector gathers the word at a single (row, column) position from every matrix of a volume, so the next stage can run its transform across the matrix axis.

Reordering uses shift chains and multiplexers only, with no addressed memory. A staircase of word delays turns each incoming row into a word-serial feed. A per-row selector routes that feed into one of `LANES` line-delay chains, one chain per row index. Each chain has one tap per matrix. A single shared select then picks which chain drives the output register, and it moves to the next chain once every `LANES` outputs. The whole pipeline advances only on cycles with `inValid` high. A gap in the input stream freezes it, and streaming resumes where it stopped.

Top module: `volume_transposer`

## Requirements
- R1: Input word c sits at bits [c*WORD_W +: WORD_W] of `inVec` and is column c of the current row. On every cycle with `outValid` high, output word k (bits [k*WORD_W +: WORD_W] of `outVec`) holds the element at the reported (row, column) of matrix k of the same volume, so the words run in matrix order.
- R2: Output vectors follow raster order within a volume. The column advances on every output and the row advances after `LANES` outputs. Volumes follow one another without a break. Exactly one vector is produced for each accepted row beyond the first LANES*LANES-LANES+1 accepted rows.
- R3: Counting accepted edges from 0 after reset, `outValid` stays low until the edge numbered LANES*LANES-LANES+1 (57 for LANES=8). That edge loads the vector for position (0,0).
- R4: Once that latency has elapsed, every edge that accepts a row also loads an output, so `outValid` stays high while `inValid` is held high, across volume boundaries.
- R5: An edge with `inValid` low is a stall. No state advances, `outValid` is low afterwards, `outVec` keeps its previous value, and the data on `inVec` is ignored. When input resumes, the output sequence continues as if the gap had not occurred.
- R6: While `rstN` is low, `outValid` and `outVec` are zero. After release, the latency of R3 is counted afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Row on `inVec` is accepted at this edge |
| inVec | input | LANES*WORD_W | One coefficient row, word c = column c |
| outValid | output | 1 | `outVec` was loaded at the last edge |
| outVec | output | LANES*WORD_W | Word k = same position taken from matrix k |

## Verification
Accepted edges are numbered from 0 after reset. The vector for row r, column c of volume v is loaded at accepted edge 57 + 64v + 8r + c, and `outValid` rises at that same edge. A stall shows at the edge it occurs, as `outValid` low with `outVec` frozen. The bench samples 1 ns after each rising edge and keeps its own count of accepted edges. It expects the first valid output exactly when that count reaches 58, then derives every expected vector from the running output index alone. That index is reset together with the design, so inserted gaps and a reset in mid-stream move the schedule without shifting the expectations.

// File: rtl/vtr_pkg.sv
package vtr_pkg;

  localparam int unsigned VTR_LANES  = 8;
  localparam int unsigned VTR_WORD_W = 16;

  // Strobes from control to datapath, one per accepted/loaded event.
  typedef struct packed {
    logic shiftEn;    // advance every chain by one step
    logic captureEn;  // load the output register from the selected chain
  } vtr_strobe_t;

endpackage

// File: rtl/volume_transposer_ctrl.sv
module volume_transposer_ctrl
  import vtr_pkg::*;
#(
  parameter int unsigned LANES = VTR_LANES
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output vtr_strobe_t                strobe,
  output logic [$clog2(LANES)-1:0]   feedPhase,
  output logic [$clog2(LANES)-1:0]   rowSel,
  output logic                       outValid
);

  localparam int unsigned SEL_W   = $clog2(LANES);
  localparam int unsigned LATENCY = LANES * LANES - LANES + 1;
  localparam int unsigned WARM_W  = $clog2(LATENCY + 1);
  localparam int unsigned RD_W    = 2 * SEL_W;

  logic [WARM_W-1:0] warmCnt;
  logic [RD_W-1:0]   readCnt;
  logic              primed;

  assign primed = (warmCnt == WARM_W'(LATENCY));

  always_comb begin
    strobe.shiftEn   = inValid;
    strobe.captureEn = inValid && primed;
  end

  // Output group select: one chain per LANES outputs, wraps after LANES^2.
  assign rowSel = readCnt[RD_W-1:SEL_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt   <= '0;
      feedPhase <= '0;
      readCnt   <= '0;
      outValid  <= 1'b0;
    end else begin
      outValid <= strobe.captureEn;
      if (strobe.shiftEn) begin
        feedPhase <= feedPhase + 1'b1;
        if (!primed) warmCnt <= warmCnt + 1'b1;
      end
      if (strobe.captureEn) readCnt <= readCnt + 1'b1;
    end
  end

endmodule

// File: rtl/volume_transposer_dp.sv
module volume_transposer_dp
  import vtr_pkg::*;
#(
  parameter int unsigned LANES  = VTR_LANES,
  parameter int unsigned WORD_W = VTR_WORD_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  vtr_strobe_t                strobe,
  input  logic [$clog2(LANES)-1:0]   feedPhase,
  input  logic [$clog2(LANES)-1:0]   rowSel,
  input  logic [LANES*WORD_W-1:0]    inVec,
  output logic [LANES*WORD_W-1:0]    outVec
);

  localparam int unsigned SEL_W  = $clog2(LANES);
  localparam int unsigned BASE_Q = LANES * (LANES - 1);

  logic [LANES-1:0][WORD_W-1:0]             skewOut;
  logic [LANES-1:0][LANES-1:0][WORD_W-1:0]  taps;   // [row chain][matrix]

  // Staircase: column c is delayed by c accepted cycles.
  for (genvar c = 0; c < LANES; c++) begin : g_skew
    if (c == 0) begin : g_direct
      assign skewOut[c] = inVec[WORD_W-1:0];
    end else begin : g_delay
      logic [WORD_W-1:0] stage [c];
      always_ff @(posedge clk) begin
        if (strobe.shiftEn) begin
          stage[0] <= inVec[c*WORD_W +: WORD_W];
          for (int j = 1; j < c; j++) stage[j] <= stage[j-1];
        end
      end
      assign skewOut[c] = stage[c-1];
    end
  end

  // One line-delay chain per row index; chain r is longer by (LANES-1)*r.
  for (genvar r = 0; r < LANES; r++) begin : g_line
    localparam int unsigned DEPTH = BASE_Q + (LANES - 1) * r + 1;
    logic [SEL_W-1:0]  pick;
    logic [WORD_W-1:0] line [DEPTH];

    assign pick = feedPhase - SEL_W'(r);

    always_ff @(posedge clk) begin
      if (strobe.shiftEn) begin
        line[0] <= skewOut[pick];
        for (int j = 1; j < DEPTH; j++) line[j] <= line[j-1];
      end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_tap
      assign taps[r][k] = line[DEPTH - 1 - LANES * k];
    end
  end

  // Output multiplexers: all lanes share rowSel.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outVec <= '0;
    else if (strobe.captureEn) outVec <= taps[rowSel];
  end

endmodule

// File: rtl/volume_transposer.sv
module volume_transposer
  import vtr_pkg::*;
#(
  parameter int unsigned LANES  = VTR_LANES,
  parameter int unsigned WORD_W = VTR_WORD_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [LANES*WORD_W-1:0] inVec,
  output logic                    outValid,
  output logic [LANES*WORD_W-1:0] outVec
);

  localparam int unsigned SEL_W = $clog2(LANES);

  vtr_strobe_t      strobe;
  logic [SEL_W-1:0] feedPhase;
  logic [SEL_W-1:0] rowSel;

  volume_transposer_ctrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .strobe    (strobe),
    .feedPhase (feedPhase),
    .rowSel    (rowSel),
    .outValid  (outValid)
  );

  volume_transposer_dp #(.LANES(LANES), .WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .feedPhase (feedPhase),
    .rowSel    (rowSel),
    .inVec     (inVec),
    .outVec    (outVec)
  );

endmodule

// File: rtl/volume_transposer_chk.sv
module volume_transposer_chk #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned WORD_W = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    outValid,
  input logic [LANES*WORD_W-1:0] outVec
);

  localparam int unsigned LATENCY = LANES * LANES - LANES + 1;
  localparam int unsigned CNT_W   = $clog2(LATENCY + 2);

  logic [CNT_W-1:0] acceptCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acceptCnt <= '0;
    else if (inValid && acceptCnt <= CNT_W'(LATENCY)) acceptCnt <= acceptCnt + 1'b1;
  end

  a_r3_no_early_valid: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (acceptCnt > CNT_W'(LATENCY)));

  a_r4_valid_sustained: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && acceptCnt >= CNT_W'(LATENCY)) |=> outValid);

  a_r5_gap_drops_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r5_gap_holds_data: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outVec));

  a_r6_reset_clears_valid: assert property (@(posedge clk)
    !rstN |=> !outValid);

endmodule

bind volume_transposer volume_transposer_chk #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .outVec   (outVec)
);

// File: tb/test_volume_transposer.sv
`timescale 1ns/1ps
module test_volume_transposer;

  localparam int LANES   = 8;
  localparam int WORD_W  = 16;
  localparam int VEC_W   = LANES * WORD_W;
  localparam int LATENCY = LANES * LANES - LANES + 1;
  localparam int VOL     = LANES * LANES;

  logic             clk = 1'b0;
  logic             rstN;
  logic             inValid;
  logic [VEC_W-1:0] inVec;
  logic             outValid;
  logic [VEC_W-1:0] outVec;

  int  checks = 0;
  int  errors = 0;
  int  acc = 0;         // accepted edges since reset
  int  outIdx = 0;      // outputs seen since reset
  bit  seenFirst = 0;
  bit  done = 0;
  int  pat = 0;
  logic [VEC_W-1:0] prevVec = '0;

  always #2 clk = ~clk;

  volume_transposer #(.LANES(LANES), .WORD_W(WORD_W)) i_volume_transposer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inVec(inVec),
    .outValid(outValid), .outVec(outVec)
  );

  function automatic logic [WORD_W-1:0] elem(int p, int v, int k, int r, int c);
    logic [WORD_W-1:0] mask;
    mask = (p != 0) ? 16'h5A5A : 16'h0000;
    return WORD_W'((v << 9) | (k << 6) | (r << 3) | c) ^ mask;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic driveRow(input int g);
    @(negedge clk);
    inValid = 1'b1;
    for (int c = 0; c < LANES; c++)
      inVec[c*WORD_W +: WORD_W] = elem(pat, g / VOL, (g / LANES) % LANES, g % LANES, c);
  endtask

  task automatic gap(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
      inVec   = {VEC_W{1'b1}};
    end
  endtask

  // Monitor: samples 1 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rstN) begin
        chk(outValid == 1'b0, "R6", "valid in reset", VEC_W'(outValid), '0);
        chk(outVec == '0, "R6", "data in reset", outVec, '0);
        acc = 0; outIdx = 0; seenFirst = 0;
      end else begin
        if (inValid) acc++;
        if (!inValid && acc > 0) begin
          chk(outValid == 1'b0, "R5", "valid after stall", VEC_W'(outValid), '0);
          chk(outVec == prevVec, "R5", "data held in stall", outVec, prevVec);
        end
        if (acc <= LATENCY)
          chk(outValid == 1'b0, "R3", "early valid", VEC_W'(outValid), '0);
        else if (inValid)
          chk(outValid == 1'b1, "R4", "valid sustained", VEC_W'(outValid), VEC_W'(1));
        if (outValid && !seenFirst) begin
          seenFirst = 1;
          chk(acc == LATENCY + 1, "R3", "first valid edge", VEC_W'(acc), VEC_W'(LATENCY + 1));
        end
        if (outValid) begin
          logic [VEC_W-1:0] expVec;
          logic [WORD_W-1:0] w0;
          int v, r, c, decoded;
          v = outIdx / VOL; r = (outIdx / LANES) % LANES; c = outIdx % LANES;
          for (int k = 0; k < LANES; k++) expVec[k*WORD_W +: WORD_W] = elem(pat, v, k, r, c);
          chk(outVec == expVec, "R1", "gathered vector", outVec, expVec);
          w0 = outVec[WORD_W-1:0] ^ ((pat != 0) ? 16'h5A5A : 16'h0000);
          decoded = int'(w0 >> 9) * VOL + int'(w0 & 16'h003F);
          chk(decoded == outIdx, "R2", "raster position", VEC_W'(decoded), VEC_W'(outIdx));
          outIdx++;
        end
      end
      prevVec = outVec;
    end
  end

  // Stimulus.
  initial begin
    int g;
    rstN = 1'b0; inValid = 1'b0; inVec = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    pat = 0; g = 0;
    for (int i = 0; i < 3 * VOL; i++) driveRow(g++);
    for (int i = 0; i < 2 * VOL; i++) begin
      if (i % 13 == 5) gap(1 + i % 3);
      driveRow(g++);
    end
    gap(6);
    @(negedge clk);
    chk(outIdx == acc - LATENCY, "R2", "output count segment 1",
        VEC_W'(outIdx), VEC_W'(acc - LATENCY));
    rstN = 1'b0; inValid = 1'b0;
    repeat (3) @(negedge clk);
    pat = 1; rstN = 1'b1; g = 0;
    for (int i = 0; i < 2 * VOL; i++) driveRow(g++);
    gap(3);
    @(negedge clk);
    chk(outIdx == acc - LATENCY, "R2", "output count segment 2",
        VEC_W'(outIdx), VEC_W'(acc - LATENCY));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Watchdog.
  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog expired, stream did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule